// File: doc/BRIEF.md
# Coincident-edge sync pulse generator

This block sits beside two clock dividers that are fed by the same fast source clock. One divider produces the bank A clock and the other produces the bank C clock. When the two ratios are not whole multiples of one another, a receiver cannot easily tell which rising edges of the two clocks coincide. The block gives it a marker for this. Its output, `sync_n`, normally sits high. It drops low for one period of the faster of the two divided clocks. The low pulse ends exactly one such period before each rising edge that both clocks share.

The block does not see the divided clocks. It knows only the two divide ratios, given in source clock cycles, and it assumes both dividers are released from reset together with it. Both divided clocks therefore rise at source cycle index 0. A residue tracker for each clock predicts whether the faster-clock edge two periods ahead is a shared edge, and the output register turns that prediction into the pulse. An enable input can park the output low. Enabling and parking take effect only on faster-clock period boundaries, so no shortened pulse or gap is ever produced. The ratios must stay constant between resets.

Top module: `coin_sync_gen`

## Requirements
- R1: While `rst_n` is low, `sync_n` is high, whatever the ratios and `sync_en` are.
- R2: Let index t count source clock rising edges after reset release, with t = 0 at the first edge at which `rst_n` is sampled high. The value for index t is driven on `sync_n` from edge t until edge t+1. Each low pulse lasts exactly P indices, where P = min(`ratio_a`, `ratio_c`), and the output is high outside the pulses.
- R3: Both divided clocks rise at index 0 and then every `ratio_a` or `ratio_c` indices, so shared edges fall at multiples of L = lcm(`ratio_a`, `ratio_c`). When L > P, `sync_n` is low exactly when (t mod L) lies in [L-2P, L-P).
- R4: When the two ratios are equal, `sync_n` alternates low and high every P indices, starting low at index 0.
- R5: Integer relations between the two clocks (2:1, 3:1, 4:1, 6:1) follow R3.
- R6: Non-integer relations (3:2, 4:3, 5:3) follow R3.
- R7: Swapping the two ratio inputs gives the same `sync_n` sequence.
- R8: `sync_en` = 0 parks `sync_n` low, and `sync_en` = 1 lets the pulses through. The level is sampled only at indices that are multiples of P, and it governs the P indices that start there.
- R9: `sync_n` changes value only at indices that are multiples of P.
- R10: A ratio of 1, where the faster clock is the source clock itself, gives one-index pulses that follow R3. Ratios 1:1 follow R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast source clock shared with both dividers |
| rst_n | input | 1 | Synchronous active-low reset, released together with the dividers |
| ratio_a | input | DIV_W | Bank A divide ratio in source cycles (1 or more) |
| ratio_c | input | DIV_W | Bank C divide ratio in source cycles (1 or more) |
| sync_en | input | 1 | 1 lets pulses through, 0 parks the output low |
| sync_n | output | 1 | Active-low sync pulse |

## Verification
The value for index t appears one register stage after the edge that processes t. The bench therefore samples `sync_n` on the falling edge that follows each rising edge. The first sample after reset release corresponds to index 0. A change of `sync_en` driven before edge t is expected to matter only from the next multiple of P, and the queued expectations are built with that boundary sampling. The reset value is read at a falling edge while reset is still held.

// File: rtl/coin_sync_pkg.sv
package coin_sync_pkg;
   localparam int unsigned MON_CNT = 2;
   typedef enum int unsigned {
      MON_A = 0,
      MON_C = 1
   } mon_e;
endpackage

// File: rtl/csg_phase_ctr.sv
module csg_phase_ctr #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] step,
   output logic             at_boundary,
   output logic             wrap,
   output logic             tog
);
   logic [DIV_W-1:0] phase;

   assign wrap        = (phase == step - 1'b1);
   assign at_boundary = (phase == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
         tog   <= 1'b1;
      end else if (wrap) begin
         phase <= '0;
         tog   <= ~tog;
      end else begin
         phase <= phase + 1'b1;
      end
   end

   // R9: position inside the faster period never leaves its range
   p_phase_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      phase < step);
endmodule

// File: rtl/csg_edge_pred.sv
module csg_edge_pred #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic [DIV_W-1:0] step,
   input  logic             adv,
   output logic             hit
);
   localparam int EW = DIV_W + 1;

   logic [EW-1:0] div_x, two_p, s1, s2, sum, next_r, res;

   assign div_x  = {1'b0, div};
   assign two_p  = {step, 1'b0};
   assign s1     = (two_p >= div_x) ? two_p - div_x : two_p;
   assign s2     = (s1 >= div_x) ? s1 - div_x : s1;
   assign sum    = res + {1'b0, step};
   assign next_r = (sum >= div_x) ? sum - div_x : sum;
   assign hit    = (res == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)   res <= s2;
      else if (adv) res <= next_r;
   end

   // R3: residue of the look-ahead edge stays below the ratio
   p_res_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      res < div_x);
   // R2: the faster clock itself rises on every look-ahead edge
   p_fast_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (div == step) |-> hit);
endmodule

// File: rtl/csg_out_gate.sv
module csg_out_gate #(
   parameter int BOUNDARY_FREEZE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic at_boundary,
   input  logic pulse_due,
   input  logic en_in,
   output logic sync_n
);
   logic en_use;

   generate
      if (BOUNDARY_FREEZE != 0) begin : g_aligned
         logic en_q;
         assign en_use = at_boundary ? en_in : en_q;
         always_ff @(posedge clk) begin
            if (!rst_n) en_q <= 1'b1;
            else        en_q <= en_use;
         end
         // R9: output moves only on faster-period boundaries
         p_edge_on_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (sync_n != $past(sync_n)) |-> $past(at_boundary));
      end else begin : g_direct
         assign en_use = en_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sync_n <= 1'b1;
      else        sync_n <= en_use & ~pulse_due;
   end

   // R8: a parked output reads low
   p_parked_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_use |=> !sync_n);
endmodule

// File: rtl/coin_sync_gen.sv
module coin_sync_gen
   import coin_sync_pkg::*;
#(
   parameter int DIV_W           = 5,
   parameter int BOUNDARY_FREEZE = 1
) (
   input  logic             src_clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] ratio_a,
   input  logic [DIV_W-1:0] ratio_c,
   input  logic             sync_en,
   output logic             sync_n
);
   generate
      if (DIV_W < 2 || DIV_W > 16) begin : g_bad_width
         $error("coin_sync_gen: DIV_W out of range");
      end
      if (BOUNDARY_FREEZE != 0 && BOUNDARY_FREEZE != 1) begin : g_bad_mode
         $error("coin_sync_gen: BOUNDARY_FREEZE must be 0 or 1");
      end
   endgenerate

   logic [DIV_W-1:0] ratios [MON_CNT];
   logic [MON_CNT-1:0] hits;
   logic [DIV_W-1:0] step;
   logic same, at_boundary, wrap, tog, pulse_due;

   assign ratios[MON_A] = ratio_a;
   assign ratios[MON_C] = ratio_c;
   assign step = (ratio_a < ratio_c) ? ratio_a : ratio_c;
   assign same = (ratio_a == ratio_c);

   csg_phase_ctr #(.DIV_W(DIV_W)) u_phase (
      .clk(src_clk), .rst_n(rst_n), .step(step),
      .at_boundary(at_boundary), .wrap(wrap), .tog(tog)
   );

   generate
      for (genvar i = 0; i < MON_CNT; i++) begin : g_mon
         csg_edge_pred #(.DIV_W(DIV_W)) u_pred (
            .clk(src_clk), .rst_n(rst_n), .div(ratios[i]), .step(step),
            .adv(wrap), .hit(hits[i])
         );
      end
   endgenerate

   // R4: with equal ratios every edge is shared, so alternate periods are used
   assign pulse_due = (&hits) & (~same | tog);

   csg_out_gate #(.BOUNDARY_FREEZE(BOUNDARY_FREEZE)) u_gate (
      .clk(src_clk), .rst_n(rst_n), .at_boundary(at_boundary),
      .pulse_due(pulse_due), .en_in(sync_en), .sync_n(sync_n)
   );

   // R4: equal ratios never produce two pulses in consecutive periods
   p_equal_alt_r4: assert property (@(posedge src_clk) disable iff (!rst_n)
      (same && wrap && pulse_due) |=> !pulse_due);
endmodule

// File: tb/tb_coin_sync_gen.sv
module tb_coin_sync_gen;
   localparam int DW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DW-1:0] ratio_a = 4;
   logic [DW-1:0] ratio_c = 4;
   logic sync_en = 1'b1;
   wire  sync_n;

   int  n_run = 0;
   int  n_fail = 0;
   bit  live = 1'b0;
   int  mon_t = 0;
   string cur_tag = "";
   bit  exp_q[$];

   always #10 clk = ~clk;

   coin_sync_gen #(.DIV_W(DW)) dut (
      .src_clk(clk), .rst_n(rst_n), .ratio_a(ratio_a), .ratio_c(ratio_c),
      .sync_en(sync_en), .sync_n(sync_n)
   );

   task automatic check(logic got, bit expv, string tag, int t);
      n_run++;
      if (got !== expv) begin
         n_fail++;
         $display("FAIL %s at index %0d: sync_n=%b expected %b", tag, t, got, expv);
      end
   endtask

   // monitor: pops one expectation per cycle, sampled on the falling edge
   always @(negedge clk) begin
      if (live && exp_q.size() > 0) begin
         bit e;
         e = exp_q.pop_front();
         check(sync_n, e, cur_tag, mon_t);
         mon_t++;
      end
   end

   function automatic int gcd(int x, int y);
      int a = x;
      int b = y;
      while (b != 0) begin
         int r = a % b;
         a = b;
         b = r;
      end
      return a;
   endfunction

   function automatic bit parked(int t, int p, int f0, int f1);
      int t0 = t - (t % p);
      return (t0 >= f0) && (t0 < f1);
   endfunction

   task automatic run_case(int na, int nc, int cycles, int f0, int f1, string tag);
      int p, l, m;
      @(negedge clk);
      live    = 1'b0;
      rst_n   = 1'b0;
      ratio_a = na[DW-1:0];
      ratio_c = nc[DW-1:0];
      sync_en = 1'b0;
      repeat (2) @(negedge clk);
      check(sync_n, 1'b1, {"R1 reset high ", tag}, -1);
      p = (na < nc) ? na : nc;
      l = (na / gcd(na, nc)) * nc;
      m = (l == p) ? 2 * p : l;
      for (int t = 0; t < cycles; t++) begin
         bit low;
         low = ((t % m) >= m - 2 * p) && ((t % m) < m - p);
         exp_q.push_back(!parked(t, p, f0, f1) && !low);
      end
      cur_tag = tag;
      mon_t   = 0;
      sync_en = !parked(0, p, f0, f1) ? 1'b1 : 1'b0;
      // park inputs drive the raw level; the design samples it at boundaries
      sync_en = !((0 >= f0) && (0 < f1));
      rst_n   = 1'b1;
      @(posedge clk);
      live = 1'b1;
      for (int t = 1; t < cycles; t++) begin
         @(negedge clk);
         sync_en = !((t >= f0) && (t < f1));
      end
      repeat (2) @(posedge clk);
      if (exp_q.size() != 0) begin
         n_run++;
         n_fail++;
         $display("FAIL %s: %0d expectations left unchecked, expected 0", tag, exp_q.size());
         exp_q.delete();
      end
      live = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      run_case(4, 4, 40, 999, 999, "R4 R2 R9 equal 4:4");
      run_case(8, 4, 48, 999, 999, "R5 R3 R2 2:1");
      run_case(12, 4, 48, 999, 999, "R5 R3 3:1");
      run_case(16, 4, 64, 999, 999, "R5 R3 4:1");
      run_case(24, 4, 72, 999, 999, "R5 R3 6:1");
      run_case(6, 4, 48, 999, 999, "R6 R3 R2 3:2");
      run_case(8, 6, 72, 999, 999, "R6 R3 R9 4:3");
      run_case(10, 6, 90, 999, 999, "R6 R3 5:3");
      run_case(4, 8, 48, 999, 999, "R7 swapped 1:2");
      run_case(6, 8, 72, 999, 999, "R7 swapped 3:4");
      run_case(1, 3, 30, 999, 999, "R10 R3 ratio one 1:3");
      run_case(1, 1, 20, 999, 999, "R10 R4 ratio one 1:1");
      run_case(8, 6, 96, 27, 53, "R8 R9 park mid-period");
      run_case(3, 3, 36, 4, 11, "R8 R4 park equal");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule